// File: doc/BRIEF.md
# Byte-Wide Random Source Register File

This block puts a small byte-addressed register file in front of an internal pseudo-random bit source. The source is a linear feedback shift register (LFSR). It stands in for a physical noise source. Software turns the source on through an enable bit. It then waits for a ready flag and collects one random byte per read of the data register.

The enable bit sits in the same register as a fixed presence flag, so software changes it with a read-modify-write. The source only runs while it is enabled and no byte is waiting. Once eight fresh bits have been gathered, the byte is frozen in a holding register and the ready flag rises. The source then pauses until that byte is consumed, so no generated bit is ever lost or skipped.

Widths, seed, feedback taps and the number of bits produced per clock are parameters. When the presence parameter is 0, the presence flag reads 0 and the enable bit cannot be set.

Top module: `rngb_top`

## Requirements
- R1: The block decodes byte offsets 0 (control), 1 (status) and 2 (data). Any other offset reads 0x00, and writes to it change nothing.
- R2: Bit 6 of offset 0 is the presence flag. It reads 1 at the default parameters, and writes cannot alter it.
- R3: Bit 0 of offset 0 is the enable bit. A write to offset 0 loads it from write-data bit 0, and the next read returns it. Bits 1 to 5 and 7 of offset 0 always read 0.
- R4: After reset, offset 0 reads 0x40, offset 1 reads 0x00 and offset 2 reads 0x00.
- R5: Offset 1 reads 0x01 when a byte is waiting and 0x00 otherwise. After enable is written from a reset or consumed state, the status flag is first seen set on the 9th bus cycle after the write (eight source steps).
- R6: Each source step computes the feedback bit as the XOR of the state bits under mask 0xD008, from the 16-bit seed 0xACE1, and shifts it in at bit 0. The first bit generated lands in data bit 7, so each byte is eight consecutive feedback bits, MSB first.
- R7: A read of offset 2 while a byte is waiting returns that byte and clears the status flag. The next byte follows after eight more steps. A waiting byte stays unchanged until it is read.
- R8: A read of offset 2 while no byte is waiting returns the previous byte again. It does not disturb the step count or the flag.
- R9: While enable is 0 the source does not step. A partly filled byte keeps its gathered bits and count, and completes after the remaining steps once enable is set again.
- R10: Writes to offsets 1 and 2 have no effect on the flag, on the waiting byte or on the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as a read strobe |

## Verification
The hardest state to reach from the bus is a byte that is only partly gathered while the source is disabled. The bench reaches it by disabling the source while a byte is waiting and consuming that byte, which leaves the step count at zero. It then enables the source for exactly three steps and disables it again. The bench counts the status polls until the byte completes after re-enabling. Every byte value is predicted by a separate model of the shift-register sequence. Because no bits are dropped, the byte order does not depend on how the steps were spread over time.

// File: rtl/rngb_pkg.sv
`timescale 1ns/1ps
package rngb_pkg;
   localparam int BYTE_W     = 8;
   localparam int CTL_EN_BIT = 0;
   localparam int CTL_FIT_BIT = 6;
   localparam int STS_RDY_BIT = 0;

   typedef enum logic [1:0] {
      OFF_CTL  = 2'd0,
      OFF_STS  = 2'd1,
      OFF_DATA = 2'd2,
      OFF_NONE = 2'd3
   } rngb_off_e;
endpackage

// File: rtl/rngb_lfsr.sv
`timescale 1ns/1ps
module rngb_lfsr #(
   parameter int           W     = 16,
   parameter logic [W-1:0] TAPS  = 16'hD008,
   parameter logic [W-1:0] SEED  = 16'hACE1,
   parameter int           NBITS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [NBITS-1:0] bits_o
);
   logic [W-1:0] state_q;
   logic [W-1:0] state_nxt;

   if (W < 3) begin : g_bad_w
      $error("rngb_lfsr: W must be at least 3");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("rngb_lfsr: SEED must be nonzero");
   end
   if (!TAPS[W-1]) begin : g_bad_taps
      $error("rngb_lfsr: TAPS must include the top state bit");
   end

   if (NBITS == 1) begin : g_single
      // XOR chain over the tap mask, one stage per state bit
      logic [W-1:0] chain;
      assign chain[0] = TAPS[0] & state_q[0];
      for (genvar i = 1; i < W; i++) begin : g_chain
         assign chain[i] = chain[i-1] ^ (TAPS[i] & state_q[i]);
      end
      assign bits_o    = chain[W-1];
      assign state_nxt = {state_q[W-2:0], chain[W-1]};
   end else begin : g_multi
      // several steps unrolled per clock; earliest bit goes highest
      always_comb begin
         logic [W-1:0] s;
         logic         fb;
         s      = state_q;
         bits_o = '0;
         for (int k = 0; k < NBITS; k++) begin
            fb                 = ^(s & TAPS);
            bits_o[NBITS-1-k]  = fb;
            s                  = {s[W-2:0], fb};
         end
         state_nxt = s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= SEED;
      else if (step_i) state_q <= state_nxt;
   end
endmodule

// File: rtl/rngb_harvest.sv
`timescale 1ns/1ps
module rngb_harvest #(
   parameter int NBITS = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en_i,
   input  logic                      take_i,
   input  logic [NBITS-1:0]          bits_i,
   output logic                      step_o,
   output logic                      ready_o,
   output logic [rngb_pkg::BYTE_W-1:0] byte_o
);
   import rngb_pkg::*;

   localparam int SPB   = BYTE_W / NBITS;
   localparam int CNT_W = (SPB > 1) ? $clog2(SPB) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SPB - 1);

   if (!(NBITS == 1 || NBITS == 2 || NBITS == 4 || NBITS == 8)) begin : g_bad_nbits
      $error("rngb_harvest: NBITS must divide the byte width");
   end

   logic [BYTE_W-1:0]       acc_q;
   logic [BYTE_W-1:0]       hold_q;
   logic [CNT_W-1:0]        cnt_q;
   logic                    ready_q;
   logic [BYTE_W+NBITS-1:0] cat;
   logic [BYTE_W-1:0]       acc_nxt;
   logic                    unused_hi;

   assign cat       = {acc_q, bits_i};
   assign acc_nxt   = cat[BYTE_W-1:0];
   assign unused_hi = ^cat[BYTE_W+NBITS-1:BYTE_W];

   // source runs only when enabled and the holding slot is free
   assign step_o  = en_i & ~ready_q;
   assign ready_o = ready_q;
   assign byte_o  = hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         hold_q  <= '0;
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (take_i) begin
         ready_q <= 1'b0;
      end else if (step_o) begin
         acc_q <= acc_nxt;
         if (cnt_q == LAST) begin
            cnt_q   <= '0;
            hold_q  <= acc_nxt;
            ready_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rngb_regif.sv
`timescale 1ns/1ps
module rngb_regif #(
   parameter int ADDR_W = 2,
   parameter bit FITTED = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [rngb_pkg::BYTE_W-1:0] bus_wdata,
   input  logic                        ready_i,
   input  logic [rngb_pkg::BYTE_W-1:0] byte_i,
   output logic                        en_o,
   output logic                        take_o,
   output logic [rngb_pkg::BYTE_W-1:0] bus_rdata
);
   import rngb_pkg::*;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("rngb_regif: ADDR_W must be at least 2");
   end

   logic      hi_zero;
   rngb_off_e off;
   logic      rd_hit;
   logic      wr_ctl;
   logic      unused_wdata;

   if (ADDR_W > 2) begin : g_hi
      assign hi_zero = ~|bus_addr[ADDR_W-1:2];
   end else begin : g_nohi
      assign hi_zero = 1'b1;
   end

   assign off          = rngb_off_e'(bus_addr[1:0]);
   assign rd_hit       = bus_sel & ~bus_wr & hi_zero;
   assign wr_ctl       = bus_sel & bus_wr & hi_zero & (off == OFF_CTL);
   assign take_o       = rd_hit & (off == OFF_DATA) & ready_i;
   assign unused_wdata = ^bus_wdata;

   if (FITTED) begin : g_fitted
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      en_q <= 1'b0;
         else if (wr_ctl) en_q <= bus_wdata[CTL_EN_BIT];
      end
      assign en_o = en_q;
   end else begin : g_absent
      assign en_o = 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         unique case (off)
            OFF_CTL: begin
               bus_rdata[CTL_EN_BIT]  = en_o;
               bus_rdata[CTL_FIT_BIT] = FITTED;
            end
            OFF_STS:  bus_rdata[STS_RDY_BIT] = ready_i;
            OFF_DATA: bus_rdata = byte_i;
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/rngb_top.sv
`timescale 1ns/1ps
module rngb_top #(
   parameter int               ADDR_W    = 2,
   parameter bit               FITTED    = 1'b1,
   parameter int               LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   parameter int               BITS_PER_CYCLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);
   logic                      en_w;
   logic                      take_w;
   logic                      step_w;
   logic                      rdy_w;
   logic [7:0]                byte_w;
   logic [BITS_PER_CYCLE-1:0] bits_w;

   rngb_regif #(.ADDR_W(ADDR_W), .FITTED(FITTED)) u_regif (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata),
      .ready_i(rdy_w), .byte_i(byte_w),
      .en_o(en_w), .take_o(take_w), .bus_rdata(bus_rdata)
   );

   rngb_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED),
               .NBITS(BITS_PER_CYCLE)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .step_i(step_w), .bits_o(bits_w)
   );

   rngb_harvest #(.NBITS(BITS_PER_CYCLE)) u_harvest (
      .clk(clk), .rst_n(rst_n), .en_i(en_w), .take_i(take_w),
      .bits_i(bits_w), .step_o(step_w), .ready_o(rdy_w), .byte_o(byte_w)
   );
endmodule

// File: rtl/rngb_chk.sv
`timescale 1ns/1ps
module rngb_chk #(
   parameter int ADDR_W = 2,
   parameter bit FITTED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              en_q,
   input logic              rdy,
   input logic [7:0]        hold
);
   logic rd0, rd1, rd2, rd3, wr0, wr12;
   assign rd0  = bus_sel && !bus_wr && bus_addr == ADDR_W'(0);
   assign rd1  = bus_sel && !bus_wr && bus_addr == ADDR_W'(1);
   assign rd2  = bus_sel && !bus_wr && bus_addr == ADDR_W'(2);
   assign rd3  = bus_sel && !bus_wr && bus_addr == ADDR_W'(3);
   assign wr0  = bus_sel && bus_wr && bus_addr == ADDR_W'(0);
   assign wr12 = bus_sel && bus_wr && (bus_addr == ADDR_W'(1) || bus_addr == ADDR_W'(2));

   p_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd3 |-> bus_rdata == 8'h00);
   p_presence_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd0 |-> bus_rdata[6] == FITTED);
   p_enable_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr0 |=> en_q == ($past(bus_wdata[0]) && FITTED));
   p_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd1 |-> bus_rdata == {7'b0, rdy});
   p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd2 && rdy) |=> !rdy);
   p_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !rd2) |=> (rdy && $stable(hold)));
   p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd2 && !rdy) |=> $stable(hold));
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !rdy) |=> !rdy);
   p_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr12 && rdy) |=> (rdy && $stable(hold) && $stable(en_q)));
endmodule

bind rngb_top rngb_chk #(.ADDR_W(ADDR_W), .FITTED(FITTED)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .en_q(en_w), .rdy(rdy_w), .hold(byte_w)
);

// File: tb/rngb_top_bench.sv
`timescale 1ns/1ps
module rngb_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;

   int n_chk  = 0;
   int n_fail = 0;
   logic [15:0] m_lfsr = 16'hACE1;
   logic [7:0]  last_byte = 8'h00;

   always #2.5 clk = ~clk;

   rngb_top u_rngb_top (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   // reference stream: feedback = XOR of state under 0xD008, MSB first
   function automatic logic [7:0] model_byte();
      logic [7:0] b = 8'h00;
      for (int k = 0; k < 8; k++) begin
         logic fb = ^(m_lfsr & 16'hD008);
         m_lfsr = {m_lfsr[14:0], fb};
         b = {b[6:0], fb};
      end
      return b;
   endfunction

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [1:0] a, logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [1:0] a, output logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // status polls that read 0 before the flag shows up
   task automatic poll_ready(output int zeros);
      logic [7:0] d;
      zeros = 0;
      for (int i = 0; i < 64; i++) begin
         bus_read(2'd1, d);
         if (d[0]) begin
            check("R5 status upper bits", d, 8'h01);
            return;
         end
         zeros++;
      end
   endtask

   task automatic consume(string tag);
      logic [7:0] d;
      logic [7:0] e;
      e = model_byte();
      bus_read(2'd2, d);
      check(tag, d, e);
      last_byte = e;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      bus_read(2'd0, d); check("R4 ctl after reset", d, 8'h40);
      bus_read(2'd1, d); check("R4 status after reset", d, 8'h00);
      bus_read(2'd2, d); check("R4 data after reset", d, 8'h00);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      bus_write(2'd3, 8'hFF);
      bus_read(2'd3, d); check("R1 offset 3 reads zero", d, 8'h00);
      bus_read(2'd0, d); check("R1 offset 3 write left ctl", d, 8'h40);
   endtask

   task automatic t_enable();
      logic [7:0] d;
      int z;
      bus_write(2'd0, 8'h01);
      poll_ready(z); check("R5 steps to first byte", z, 8);
      bus_read(2'd0, d); check("R3 enable reads back", d, 8'h41);
   endtask

   task automatic t_stream();
      int z;
      for (int i = 0; i < 3; i++) begin
         consume("R6 byte value");
         poll_ready(z); check("R7 refill steps", z, 8);
      end
   endtask

   task automatic t_empty_read();
      logic [7:0] d;
      int z;
      consume("R7 byte value");
      bus_read(2'd2, d); check("R8 empty read repeats byte", d, last_byte);
      poll_ready(z); check("R8 count undisturbed", z, 7);
      consume("R8 next byte intact");
      poll_ready(z);
   endtask

   task automatic t_ignored();
      logic [7:0] d;
      bus_write(2'd1, 8'h00);
      bus_write(2'd2, 8'h00);
      bus_write(2'd0, 8'hBF);
      bus_read(2'd0, d); check("R2 presence kept, R3 reserved bits zero", d, 8'h41);
      bus_read(2'd1, d); check("R10 status after writes", d, 8'h01);
      bus_write(2'd0, 8'h40);
      bus_read(2'd0, d); check("R3 enable cleared", d, 8'h40);
      bus_read(2'd1, d); check("R10 byte kept while disabled", d, 8'h01);
   endtask

   task automatic t_pause();
      logic [7:0] d;
      int z;
      int seen;
      consume("R10 byte survived writes");
      seen = 0;
      for (int i = 0; i < 20; i++) begin
         bus_read(2'd1, d);
         seen += d[0];
      end
      check("R9 no byte while disabled", seen, 0);
      bus_write(2'd0, 8'h01);
      idle(2);
      bus_write(2'd0, 8'h00);
      seen = 0;
      for (int i = 0; i < 10; i++) begin
         bus_read(2'd1, d);
         seen += d[0];
      end
      check("R9 partial byte paused", seen, 0);
      bus_write(2'd0, 8'h01);
      poll_ready(z); check("R9 remaining steps", z, 5);
      consume("R9 byte after pause");
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_unmapped();
      t_enable();
      t_stream();
      t_empty_read();
      t_ignored();
      t_pause();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule